// File: doc/BRIEF.md
# Two-Level Lookahead Adder

A combinational unsigned adder. It takes two 16-bit operands and a carry-in, and it returns a 16-bit sum and a carry-out. The operands are split into four 4-bit slices. Each slice forms a generate bit and a propagate bit for every position. It derives its own internal carries as flat sum-of-products terms, and it reports one generate and one propagate for the whole slice.

A second lookahead stage uses the same carry equations. It takes the four slice generate/propagate pairs and the external carry-in, and it produces the carry into each slice and the final carry-out. No carry passes serially from slice to slice. For this reason the carry path depth grows with the logarithm of the width, not linearly.

The block has no clock and no reset. Its outputs follow its inputs through logic alone.

Top module: `cla_adder16`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + c_i`, with both operands taken as unsigned.
- R2: `c_o` equals bit 16 of `a_i + b_i + c_i`. For example, 16'hFFFF plus 16'h0001 with `c_i`=0 gives `sum_o`=16'h0000 and `c_o`=1.
- R3: The carry into slice k (bits 4k and up) equals bit 4k of the sum of the lower 4k operand bits plus `c_i`. A carry made in bits [3:0] therefore shows up at bit 4, bit 8 and bit 12 (for example 16'h0FFF + 16'h0001 = 16'h1000).
- R4: When every bit position propagates (`b_i` = ~`a_i`), the carry-in passes through all slices. `c_i`=0 gives `sum_o`=16'hFFFF with `c_o`=0, and `c_i`=1 gives `sum_o`=16'h0000 with `c_o`=1.
- R5: With both operands zero, `sum_o` equals `c_i` in bit 0 and zero elsewhere, and `c_o` is 0.
- R6: Alternating bit patterns add correctly. For example, 16'hAAAA + 16'hAAAA gives 16'h5554 with `c_o`=1, and 16'h5555 + 16'h5555 + 1 gives 16'hAAAB with `c_o`=0.
- R7: The outputs depend only on the present inputs. They settle within the same time step as an input change, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 16 | First unsigned operand |
| b_i | input | 16 | Second unsigned operand |
| c_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Low 16 bits of the sum |
| c_o | output | 1 | Carry out of bit 15 |

## Verification
The hardest case to reach is a carry that comes from the external carry-in or from the lowest slice and must be carried through every higher slice purely by propagate terms. Random operands almost never make all sixteen positions propagate at once. The stimulus therefore forces it directly, using complementary operands with both carry-in values, all-ones plus one, and values that cross each slice boundary with the carry. Random vectors then cover the mixed generate/propagate cases against a behavioural sum.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned GRP_W_DEF = 4;
  localparam int unsigned N_GRP_DEF = 4;
endpackage

// File: rtl/cla_carry_unit.sv
// Flattened lookahead: carry k = OR of g[j]*p[k-1..j+1], plus p[k-1..0]*cin
module cla_carry_unit #(
  parameter int unsigned N  = 4,
  parameter int unsigned CW = 4
) (
  input  logic [N-1:0]  g_i,
  input  logic [N-1:0]  p_i,
  input  logic          c_i,
  output logic [CW-1:0] c_o
);
  always_comb begin
    logic prod;
    logic acc;
    c_o = '0;
    for (int k = 1; k <= int'(CW); k++) begin
      prod = 1'b1;
      acc  = 1'b0;
      for (int j = k - 1; j >= 0; j--) begin
        acc  = acc | (prod & g_i[j]);
        prod = prod & p_i[j];
      end
      c_o[k-1] = acc | (prod & c_i);
    end
  end
endmodule

// File: rtl/cla_group_pg.sv
module cla_group_pg #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  output logic         g_o,
  output logic         p_o
);
  always_comb begin
    logic prod;
    prod = 1'b1;
    g_o  = 1'b0;
    for (int j = N - 1; j >= 0; j--) begin
      g_o  = g_o | (prod & g_i[j]);
      prod = prod & p_i[j];
    end
    p_o = prod;
  end
endmodule

// File: rtl/cla_group4.sv
module cla_group4 #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         g_o,
  output logic         p_o
);
  logic [W-1:0] bit_g, bit_p, carry;
  logic [W-2:0] c_int;

  assign bit_g = a_i & b_i;
  assign bit_p = a_i ^ b_i;

  cla_carry_unit #(.N(W), .CW(W - 1)) i_carry (
    .g_i(bit_g), .p_i(bit_p), .c_i(c_i), .c_o(c_int)
  );

  cla_group_pg #(.N(W)) i_pg (
    .g_i(bit_g), .p_i(bit_p), .g_o(g_o), .p_o(p_o)
  );

  assign carry = {c_int, c_i};
  assign s_o   = bit_p ^ carry;
endmodule

// File: rtl/cla_adder16.sv
module cla_adder16
  import cla_pkg::*;
#(
  parameter int unsigned GRP_W = GRP_W_DEF,
  parameter int unsigned N_GRP = N_GRP_DEF
) (
  input  logic [GRP_W*N_GRP-1:0] a_i,
  input  logic [GRP_W*N_GRP-1:0] b_i,
  input  logic                   c_i,
  output logic [GRP_W*N_GRP-1:0] sum_o,
  output logic                   c_o
);
  logic [N_GRP-1:0] grp_g, grp_p;
  logic [N_GRP:0]   grp_c;
  logic [N_GRP-1:0] top_c;

  for (genvar k = 0; k < N_GRP; k++) begin : g_grp
    cla_group4 #(.W(GRP_W)) i_grp (
      .a_i(a_i[k*GRP_W +: GRP_W]),
      .b_i(b_i[k*GRP_W +: GRP_W]),
      .c_i(grp_c[k]),
      .s_o(sum_o[k*GRP_W +: GRP_W]),
      .g_o(grp_g[k]),
      .p_o(grp_p[k])
    );
  end

  // second level: same equations over slice g/p
  cla_carry_unit #(.N(N_GRP), .CW(N_GRP)) i_top_carry (
    .g_i(grp_g), .p_i(grp_p), .c_i(c_i), .c_o(top_c)
  );

  assign grp_c = {top_c, c_i};
  assign c_o   = grp_c[N_GRP];
endmodule

// File: rtl/cla_adder16_chk.sv
module cla_adder16_chk #(
  parameter int unsigned GRP_W = 4,
  parameter int unsigned N_GRP = 4
) (
  input logic [GRP_W*N_GRP-1:0] a_i,
  input logic [GRP_W*N_GRP-1:0] b_i,
  input logic                   c_i,
  input logic [GRP_W*N_GRP-1:0] sum_o,
  input logic                   c_o,
  input logic [N_GRP-1:0]       grp_g,
  input logic [N_GRP-1:0]       grp_p,
  input logic [N_GRP:0]         grp_c
);
  localparam int unsigned W = GRP_W * N_GRP;

  always_comb begin
    p_sum_r1: assert ({c_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, c_i}))
      else $error("sum mismatch");
    if (a_i == '0 && b_i == '0)
      p_cin_only_r5: assert (sum_o == {{(W-1){1'b0}}, c_i} && !c_o)
        else $error("carry-in alone");
  end

  for (genvar k = 0; k < N_GRP; k++) begin : g_k
    localparam int unsigned LW = (k + 1) * GRP_W;
    logic [LW:0] low_sum;
    assign low_sum = {1'b0, a_i[LW-1:0]} + {1'b0, b_i[LW-1:0]} + {{LW{1'b0}}, c_i};
    always_comb begin
      p_grp_carry_r3: assert (grp_c[k+1] == low_sum[LW])
        else $error("slice carry %0d", k);
      p_gp_excl_r3: assert (!(grp_g[k] && grp_p[k]))
        else $error("slice g/p overlap %0d", k);
      if (grp_p[k])
        p_pass_r4: assert (grp_c[k+1] == grp_c[k])
          else $error("propagate pass %0d", k);
    end
  end
endmodule

bind cla_adder16 cla_adder16_chk #(.GRP_W(GRP_W), .N_GRP(N_GRP)) i_chk (
  .a_i(a_i), .b_i(b_i), .c_i(c_i), .sum_o(sum_o), .c_o(c_o),
  .grp_g(grp_g), .grp_p(grp_p), .grp_c(grp_c)
);

// File: tb/test_cla_adder16.sv
module test_cla_adder16;
  localparam int CLK_PERIOD = 10;
  localparam int N_VEC = 13;
  localparam int N_RAND = 2000;

  logic clk = 1'b0;
  logic [15:0] a, b, sum;
  logic cin, cout;
  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // {a, b, cin, exp_sum, exp_cout}
  localparam logic [49:0] VEC [N_VEC] = '{
    {16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0},
    {16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1},
    {16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0},
    {16'hAAAA, 16'h5555, 1'b0, 16'hFFFF, 1'b0},
    {16'hAAAA, 16'h5555, 1'b1, 16'h0000, 1'b1},
    {16'hAAAA, 16'hAAAA, 1'b0, 16'h5554, 1'b1},
    {16'h5555, 16'h5555, 1'b1, 16'hAAAB, 1'b0},
    {16'h000F, 16'h0001, 1'b0, 16'h0010, 1'b0},
    {16'h00FF, 16'h0001, 1'b0, 16'h0100, 1'b0},
    {16'h0FFF, 16'h0000, 1'b1, 16'h1000, 1'b0},
    {16'hFFFF, 16'hFFFF, 1'b1, 16'hFFFF, 1'b1},
    {16'h1234, 16'h4321, 1'b0, 16'h5555, 1'b0},
    {16'h8000, 16'h8000, 1'b0, 16'h0000, 1'b1}
  };

  cla_adder16 i_cla_adder16 (
    .a_i(a), .b_i(b), .c_i(cin), .sum_o(sum), .c_o(cout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !done) begin
      n_errors = n_errors + 1;
      n_checks = n_checks + 1;
      $display("FAIL watchdog: R7 run did not complete, got %0d cycles expected < 100000", cycles);
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [15:0] es, input logic ec);
    n_checks++;
    if (sum !== es || cout !== ec) begin
      n_errors++;
      $display("FAIL %s: a=%h b=%h cin=%b got sum=%h cout=%b expected sum=%h cout=%b",
               req, a, b, cin, sum, cout, es, ec);
    end
  endtask

  task automatic apply(input logic [15:0] va, input logic [15:0] vb, input logic vc);
    @(negedge clk);
    a = va; b = vb; cin = vc;
    #1;
  endtask

  initial begin
    logic [16:0] ref_v;
    a = '0; b = '0; cin = 1'b0;
    // R5/R7: zero inputs at start give zero outputs with no clock edge
    #1;
    check("R5", 16'h0000, 1'b0);

    for (int i = 0; i < N_VEC; i++) begin
      apply(VEC[i][49:34], VEC[i][33:18], VEC[i][17]);
      check((i == 2) ? "R5" : (i == 3 || i == 4) ? "R4" : (i == 5 || i == 6) ? "R6" :
            (i >= 7 && i <= 9) ? "R3" : (i == 1 || i == 12) ? "R2" : "R1",
            VEC[i][16:1], VEC[i][0]);
    end

    // R3: carry created in low slice reaches every boundary
    for (int k = 1; k < 4; k++) begin
      apply(16'((32'd1 << (4*k)) - 1), 16'h0001, 1'b0);
      check("R3", 16'(32'd1 << (4*k)), 1'b0);
    end

    // R4: complementary operands, both carry-in values
    for (int i = 0; i < 20; i++) begin
      logic [15:0] x;
      x = 16'($urandom);
      apply(x, ~x, 1'b0);
      check("R4", 16'hFFFF, 1'b0);
      apply(x, ~x, 1'b1);
      check("R4", 16'h0000, 1'b1);
    end

    // R7: change inputs mid-cycle, result follows without a clock edge
    @(posedge clk);
    #2;
    a = 16'h7FFF; b = 16'h0001; cin = 1'b0;
    #1;
    check("R7", 16'h8000, 1'b0);

    // R1/R2: random operands against behavioural sum
    for (int i = 0; i < N_RAND; i++) begin
      logic [15:0] ra, rb;
      logic rc;
      ra = 16'($urandom);
      rb = 16'($urandom);
      rc = 1'($urandom);
      apply(ra, rb, rc);
      ref_v = {1'b0, ra} + {1'b0, rb} + {16'd0, rc};
      check("R1", ref_v[15:0], ref_v[16]);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule